// File: doc/BRIEF.md
# Clock Frequency-Select Resolver

This block turns the contents of a small configuration register bank, plus a power-up match, into a 5-bit frequency-select index. It then looks that index up in a table fixed at elaboration time. Each table entry gives a bus frequency in 10 kHz units, a memory-clock multiplier and a PCI clock divider.

After reset the block compares a requested bus frequency with the table, one entry per clock. It picks the closest eligible entry and seeds the register bank so that the select bits agree with that choice. Then it raises `done`. From that point, register writes update the outputs.

Each of the select bits may be tied to a plain register bit, to a register bit that holds its complement, to both, or to neither. A hardware-select bit in the bank picks the mode:
- **Strap mode:** the index is the power-up match.
- **Programmable mode:** the index comes from the plain register bits.

A build option removes the hardware-select bit, and the block then always runs in programmable mode.

Top module: `clkfs_resolver`

## Requirements
- R1: While reset is held, and during the power-up search, `done` is 0 and `sel_idx`, `bus_freq`, `mem_mult` and `pci_div` are all 0.
- R2: The power-up search keeps the eligible entry with the smallest absolute difference between `req_freq` and its bus frequency. The difference is taken in FREQ_W+1 bits without wraparound. When two entries are equally close, the lower index is kept.
- R3: A select bit with neither a plain nor a complement mapping is register-only. Only entries whose index has all register-only bits at 0 are eligible. With the default map, bits 0 and 4 are register-only, so only even indices below 16 are eligible.
- R4: The search stops at the first table entry whose bus frequency is 0, or at the end of the table, whichever comes first. Entries after a zero entry are never considered.
- R5: When the search ends, every plain-mapped bit is loaded with the matching bit of the chosen index, and every complement-mapped bit with its inverse. Default map:
  - Index bits 1, 2 and 3 go to register 0 bits 4, 5 and 6.
  - The inverse of index bit 1 goes to register 1 bit 1.
  - The inverse of index bit 3 goes to register 2 bit 0.
  - All other bits keep their reset value of 0.
- R6: When the hardware-select bit (default: register 0 bit 3) is 0, `sel_idx` equals the power-up match, whatever the other register bits hold.
- R7: When the hardware-select bit is 1, each index bit is read from its plain-mapped register bit. Index bits without a plain mapping read as 0.
- R8: When built with no hardware-select bit (HW_REG equal to NREG), the block always runs in programmable mode.
- R9: One cycle after an accepted write, `bus_freq`, `mem_mult` and `pci_div` are the fields of the table entry at the new `sel_idx`. An entry holding 0 gives zeros.
- R10: Writes presented before `done` is 1 are discarded and leave the register bank unchanged.
- R11: Once `done` is 1 it stays 1 until the next reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; starts the power-up search |
| req_freq | input | FREQ_W | Requested bus frequency in 10 kHz units, held during the search |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | MAP_W | Register index for the write |
| wr_data | input | REG_W | Write data |
| rd_addr | input | MAP_W | Register index for readback |
| rd_data | output | REG_W | Register contents at `rd_addr` (0 when out of range) |
| sel_idx | output | NSEL | Resolved frequency-select index |
| bus_freq | output | FREQ_W | Bus frequency from the table entry |
| mem_mult | output | MULT_W | Memory multiplier from the table entry |
| pci_div | output | DIV_W | PCI divider from the table entry |
| done | output | 1 | Search finished; outputs valid and writes accepted |

## Verification
The checker assumes three things about the inputs:
- `req_freq` is held steady for the whole search.
- The register bank changes only through `wr_en`.
- `done` therefore marks the edge where the bank holds its seeded values.

The stimulus changes `req_freq` only while reset is held. It issues each write as a single-cycle strobe to an address inside the bank, and samples the outputs on the falling edge after the registered update. The one write that arrives before `done` is deliberate: it tests that such a write is discarded.

// File: rtl/clkfs_pkg.sv
package clkfs_pkg;
   typedef enum logic [1:0] {
      ST_SCAN  = 2'd0,
      ST_APPLY = 2'd1,
      ST_READY = 2'd2
   } clkfs_state_e;
endpackage

// File: rtl/clkfs_regbank.sv
module clkfs_regbank #(
   parameter int NREG  = 7,
   parameter int REG_W = 8,
   parameter int MAP_W = 3,
   parameter logic [NREG*REG_W-1:0] REG_INIT = '0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [MAP_W-1:0]      wr_addr,
   input  logic [REG_W-1:0]      wr_data,
   input  logic                  seed_en,
   input  logic [NREG*REG_W-1:0] seed_set,
   input  logic [NREG*REG_W-1:0] seed_clr,
   input  logic [MAP_W-1:0]      rd_addr,
   output logic [REG_W-1:0]      rd_data,
   output logic [NREG*REG_W-1:0] regs_flat
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         regs_flat <= REG_INIT;
      end else if (seed_en) begin
         regs_flat <= (regs_flat & ~seed_clr) | seed_set;
      end else if (wr_en) begin
         for (int r = 0; r < NREG; r++) begin
            if (wr_addr == MAP_W'(r)) regs_flat[r*REG_W +: REG_W] <= wr_data;
         end
      end
   end

   always_comb begin
      rd_data = '0;
      for (int r = 0; r < NREG; r++) begin
         if (rd_addr == MAP_W'(r)) rd_data = regs_flat[r*REG_W +: REG_W];
      end
   end
endmodule

// File: rtl/clkfs_decode.sv
module clkfs_decode #(
   parameter int NSEL   = 5,
   parameter int NREG   = 7,
   parameter int REG_W  = 8,
   parameter int MAP_W  = 3,
   parameter logic [NSEL*MAP_W-1:0] NORM_REG = '1,
   parameter logic [NSEL*MAP_W-1:0] NORM_BIT = '0,
   parameter logic [NSEL*MAP_W-1:0] INV_REG  = '1,
   parameter logic [NSEL*MAP_W-1:0] INV_BIT  = '0,
   parameter int HW_REG = 0,
   parameter int HW_BIT = 3
) (
   input  logic [NREG*REG_W-1:0] regs_flat,
   input  logic [NSEL-1:0]       match,
   output logic [NSEL-1:0]       idx_next,
   output logic [NSEL-1:0]       ro_mask,
   output logic [NREG*REG_W-1:0] seed_set,
   output logic [NREG*REG_W-1:0] seed_clr
);
   localparam int BANK_W = NREG*REG_W;

   logic [NSEL-1:0]   prog_bits;
   logic              strap;
   logic [BANK_W-1:0] set_v [NSEL];
   logic [BANK_W-1:0] clr_v [NSEL];

   for (genvar gi = 0; gi < NSEL; gi++) begin : g_sel
      localparam int NR = int'(NORM_REG[gi*MAP_W +: MAP_W]);
      localparam int NB = int'(NORM_BIT[gi*MAP_W +: MAP_W]);
      localparam int IR = int'(INV_REG[gi*MAP_W +: MAP_W]);
      localparam int IB = int'(INV_BIT[gi*MAP_W +: MAP_W]);
      localparam logic [BANK_W-1:0] NPOS = (NR < NREG) ? (BANK_W'(1) << (NR*REG_W + NB)) : '0;
      localparam logic [BANK_W-1:0] IPOS = (IR < NREG) ? (BANK_W'(1) << (IR*REG_W + IB)) : '0;

      // a bit with no mapping at all can only come from the table search
      assign ro_mask[gi] = (NR >= NREG) && (IR >= NREG);

      if (NR < NREG) begin : g_norm
         assign prog_bits[gi] = regs_flat[NR*REG_W + NB];
      end else begin : g_nonorm
         assign prog_bits[gi] = 1'b0;
      end

      // plain copy follows the match bit, complement copy takes the inverse
      assign set_v[gi] = match[gi] ? NPOS : IPOS;
      assign clr_v[gi] = match[gi] ? IPOS : NPOS;
   end

   if (HW_REG < NREG) begin : g_hwsel
      assign strap = ~regs_flat[HW_REG*REG_W + HW_BIT];
   end else begin : g_prog_only
      assign strap = 1'b0;
   end

   always_comb begin
      seed_set = '0;
      seed_clr = '0;
      for (int i = 0; i < NSEL; i++) begin
         seed_set = seed_set | set_v[i];
         seed_clr = seed_clr | clr_v[i];
      end
   end

   assign idx_next = strap ? match : prog_bits;
endmodule

// File: rtl/clkfs_search.sv
module clkfs_search
   import clkfs_pkg::*;
#(
   parameter int NSEL   = 5,
   parameter int FREQ_W = 15,
   parameter int ENT_W  = 20,
   parameter int DEPTH  = 16,
   parameter logic [DEPTH*ENT_W-1:0] TABLE = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [FREQ_W-1:0] req_freq,
   input  logic [NSEL-1:0]   ro_mask,
   output logic [NSEL-1:0]   match,
   output logic              seed_en,
   output logic              in_apply,
   output logic              done
);
   localparam int PW = $clog2(DEPTH + 1);

   clkfs_state_e      st;
   logic [PW-1:0]     ptr;
   logic [FREQ_W:0]   best_gap;
   logic [FREQ_W:0]   gap;
   logic [FREQ_W-1:0] cur_freq;
   logic              at_end;
   logic              eligible;

   always_comb begin
      cur_freq = '0;
      for (int k = 0; k < DEPTH; k++) begin
         if (ptr == PW'(k)) cur_freq = TABLE[k*ENT_W + ENT_W - 1 -: FREQ_W];
      end
   end

   assign gap      = (req_freq >= cur_freq) ? ({1'b0, req_freq} - {1'b0, cur_freq})
                                            : ({1'b0, cur_freq} - {1'b0, req_freq});
   assign at_end   = (ptr >= PW'(DEPTH)) || (cur_freq == '0);
   assign eligible = ((NSEL'(ptr) & ro_mask) == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st       <= ST_SCAN;
         ptr      <= '0;
         best_gap <= '1;
         match    <= '0;
      end else begin
         case (st)
            ST_SCAN: begin
               if (at_end) begin
                  st <= ST_APPLY;
               end else begin
                  if (eligible && (gap < best_gap)) begin
                     best_gap <= gap;
                     match    <= NSEL'(ptr);
                  end
                  ptr <= ptr + PW'(1);
               end
            end
            ST_APPLY: st <= ST_READY;
            ST_READY: st <= ST_READY;
            default:  st <= ST_SCAN;
         endcase
      end
   end

   assign seed_en  = (st == ST_SCAN) && at_end;
   assign in_apply = (st == ST_APPLY);
   assign done     = (st == ST_READY);
endmodule

// File: rtl/clkfs_resolver.sv
module clkfs_resolver #(
   parameter int NSEL   = 5,
   parameter int NREG   = 7,
   parameter int REG_W  = 8,
   parameter int MAP_W  = 3,
   parameter int FREQ_W = 15,
   parameter int MULT_W = 2,
   parameter int DIV_W  = 3,
   parameter int DEPTH  = 16,
   // per select bit, bit i at [i*MAP_W +: MAP_W]; register NREG means unmapped
   parameter logic [NSEL*MAP_W-1:0] NORM_REG = {3'd7, 3'd0, 3'd0, 3'd0, 3'd7},
   parameter logic [NSEL*MAP_W-1:0] NORM_BIT = {3'd0, 3'd6, 3'd5, 3'd4, 3'd0},
   parameter logic [NSEL*MAP_W-1:0] INV_REG  = {3'd7, 3'd2, 3'd7, 3'd1, 3'd7},
   parameter logic [NSEL*MAP_W-1:0] INV_BIT  = {3'd0, 3'd0, 3'd0, 3'd1, 3'd0},
   parameter int HW_REG = 0,
   parameter int HW_BIT = 3,
   parameter logic [NREG*REG_W-1:0] REG_INIT = '0,
   // entry k at [k*ENT_W +: ENT_W] = {freq, mult, div}
   parameter logic [DEPTH*(FREQ_W+MULT_W+DIV_W)-1:0] TABLE = {
      {15'd0,     2'd0, 3'd0},   // 15
      {15'd16600, 2'd2, 3'd6},   // 14
      {15'd16600, 2'd1, 3'd5},   // 13
      {15'd0,     2'd0, 3'd0},   // 12 end of table
      {15'd12000, 2'd3, 3'd5},   // 11
      {15'd13300, 2'd2, 3'd4},   // 10
      {15'd11000, 2'd1, 3'd3},   // 9
      {15'd7500,  2'd3, 3'd4},   // 8
      {15'd9500,  2'd1, 3'd3},   // 7
      {15'd10000, 2'd2, 3'd3},   // 6
      {15'd9000,  2'd1, 3'd3},   // 5
      {15'd8330,  2'd2, 3'd3},   // 4
      {15'd7000,  2'd2, 3'd2},   // 3
      {15'd7500,  2'd1, 3'd2},   // 2
      {15'd6000,  2'd0, 3'd1},   // 1
      {15'd6680,  2'd1, 3'd2}    // 0
   }
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [FREQ_W-1:0] req_freq,
   input  logic              wr_en,
   input  logic [MAP_W-1:0]  wr_addr,
   input  logic [REG_W-1:0]  wr_data,
   input  logic [MAP_W-1:0]  rd_addr,
   output logic [REG_W-1:0]  rd_data,
   output logic [NSEL-1:0]   sel_idx,
   output logic [FREQ_W-1:0] bus_freq,
   output logic [MULT_W-1:0] mem_mult,
   output logic [DIV_W-1:0]  pci_div,
   output logic              done
);
   localparam int ENT_W  = FREQ_W + MULT_W + DIV_W;
   localparam int BANK_W = NREG * REG_W;

   if (NREG >= (1 << MAP_W)) begin : g_chk_nreg
      $error("NREG must leave one MAP_W code free for unmapped");
   end
   if (REG_W > (1 << MAP_W)) begin : g_chk_regw
      $error("MAP_W too narrow for bit positions");
   end
   if (DEPTH > (1 << NSEL)) begin : g_chk_depth
      $error("DEPTH exceeds the index range");
   end
   if ((HW_REG < NREG) && (HW_BIT >= REG_W)) begin : g_chk_hw
      $error("HW_BIT outside the register");
   end

   logic [BANK_W-1:0] regs_flat;
   logic [BANK_W-1:0] seed_set;
   logic [BANK_W-1:0] seed_clr;
   logic [NSEL-1:0]   match_q;
   logic [NSEL-1:0]   idx_next;
   logic [NSEL-1:0]   ro_mask;
   logic              seed_en;
   logic              in_apply;
   logic              upd_q;
   logic              load;
   logic [ENT_W-1:0]  ent;

   clkfs_search #(
      .NSEL(NSEL), .FREQ_W(FREQ_W), .ENT_W(ENT_W), .DEPTH(DEPTH), .TABLE(TABLE)
   ) i_search (
      .clk(clk), .rst_n(rst_n), .req_freq(req_freq), .ro_mask(ro_mask),
      .match(match_q), .seed_en(seed_en), .in_apply(in_apply), .done(done)
   );

   clkfs_decode #(
      .NSEL(NSEL), .NREG(NREG), .REG_W(REG_W), .MAP_W(MAP_W),
      .NORM_REG(NORM_REG), .NORM_BIT(NORM_BIT), .INV_REG(INV_REG), .INV_BIT(INV_BIT),
      .HW_REG(HW_REG), .HW_BIT(HW_BIT)
   ) i_decode (
      .regs_flat(regs_flat), .match(match_q), .idx_next(idx_next),
      .ro_mask(ro_mask), .seed_set(seed_set), .seed_clr(seed_clr)
   );

   // R10: the write port is closed until the search has finished
   clkfs_regbank #(
      .NREG(NREG), .REG_W(REG_W), .MAP_W(MAP_W), .REG_INIT(REG_INIT)
   ) i_regbank (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en && done), .wr_addr(wr_addr),
      .wr_data(wr_data), .seed_en(seed_en), .seed_set(seed_set), .seed_clr(seed_clr),
      .rd_addr(rd_addr), .rd_data(rd_data), .regs_flat(regs_flat)
   );

   always_comb begin
      ent = '0;
      for (int k = 0; k < DEPTH; k++) begin
         if (idx_next == NSEL'(k)) ent = TABLE[k*ENT_W +: ENT_W];
      end
   end

   assign load = upd_q || in_apply;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         upd_q    <= 1'b0;
         sel_idx  <= '0;
         bus_freq <= '0;
         mem_mult <= '0;
         pci_div  <= '0;
      end else begin
         upd_q <= wr_en && done;
         if (load) begin
            sel_idx  <= idx_next;
            bus_freq <= ent[ENT_W-1 -: FREQ_W];
            mem_mult <= ent[DIV_W +: MULT_W];
            pci_div  <= ent[0 +: DIV_W];
         end
      end
   end
endmodule

// File: rtl/clkfs_resolver_chk.sv
module clkfs_resolver_chk #(
   parameter int NSEL   = 5,
   parameter int NREG   = 7,
   parameter int REG_W  = 8,
   parameter int MAP_W  = 3,
   parameter int FREQ_W = 15,
   parameter int MULT_W = 2,
   parameter int DIV_W  = 3,
   parameter int DEPTH  = 16,
   parameter logic [NSEL*MAP_W-1:0] NORM_REG = '1,
   parameter logic [NSEL*MAP_W-1:0] NORM_BIT = '0,
   parameter logic [NSEL*MAP_W-1:0] INV_REG  = '1,
   parameter logic [NSEL*MAP_W-1:0] INV_BIT  = '0,
   parameter int HW_REG = 0,
   parameter int HW_BIT = 3,
   parameter logic [DEPTH*(FREQ_W+MULT_W+DIV_W)-1:0] TABLE = '0
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  wr_en,
   input logic                  done,
   input logic [NSEL-1:0]       sel_idx,
   input logic [FREQ_W-1:0]     bus_freq,
   input logic [MULT_W-1:0]     mem_mult,
   input logic [DIV_W-1:0]      pci_div,
   input logic [NSEL-1:0]       match,
   input logic [NREG*REG_W-1:0] regs_flat
);
   localparam int ENT_W = FREQ_W + MULT_W + DIV_W;

   logic [NSEL-1:0]  ro;
   logic [ENT_W-1:0] exp_ent;
   logic             strap;

   for (genvar gi = 0; gi < NSEL; gi++) begin : g_bit
      localparam int NR = int'(NORM_REG[gi*MAP_W +: MAP_W]);
      localparam int NB = int'(NORM_BIT[gi*MAP_W +: MAP_W]);
      localparam int IR = int'(INV_REG[gi*MAP_W +: MAP_W]);
      localparam int IB = int'(INV_BIT[gi*MAP_W +: MAP_W]);
      assign ro[gi] = (NR >= NREG) && (IR >= NREG);
      if (NR < NREG) begin : g_n
         assert_seed_plain_R5: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(done) |-> (regs_flat[NR*REG_W + NB] == match[gi]));
      end
      if (IR < NREG) begin : g_i
         assert_seed_inverse_R5: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(done) |-> (regs_flat[IR*REG_W + IB] != match[gi]));
      end
   end

   if (HW_REG < NREG) begin : g_hw
      assign strap = ~regs_flat[HW_REG*REG_W + HW_BIT];
   end else begin : g_nohw
      assign strap = 1'b0;
   end

   always_comb begin
      exp_ent = '0;
      for (int k = 0; k < DEPTH; k++) begin
         if (sel_idx == NSEL'(k)) exp_ent = TABLE[k*ENT_W +: ENT_W];
      end
   end

   assert_quiet_until_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> (sel_idx == '0) && (bus_freq == '0) && (mem_mult == '0) && (pci_div == '0));

   assert_done_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> done);

   assert_match_eligible_R3: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ((match & ro) == '0));

   assert_strap_index_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (done && $past(done, 2) && !$past(wr_en) && !$past(wr_en, 2) && $past(strap))
      |-> (sel_idx == $past(match)));

   assert_table_fields_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ({bus_freq, mem_mult, pci_div} == exp_ent));
endmodule

bind clkfs_resolver clkfs_resolver_chk #(
   .NSEL(NSEL), .NREG(NREG), .REG_W(REG_W), .MAP_W(MAP_W), .FREQ_W(FREQ_W),
   .MULT_W(MULT_W), .DIV_W(DIV_W), .DEPTH(DEPTH), .NORM_REG(NORM_REG),
   .NORM_BIT(NORM_BIT), .INV_REG(INV_REG), .INV_BIT(INV_BIT),
   .HW_REG(HW_REG), .HW_BIT(HW_BIT), .TABLE(TABLE)
) i_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .done(done), .sel_idx(sel_idx),
   .bus_freq(bus_freq), .mem_mult(mem_mult), .pci_div(pci_div),
   .match(match_q), .regs_flat(regs_flat)
);

// File: tb/test_clkfs_resolver.sv
module test_clkfs_resolver;
   typedef struct packed {
      logic [14:0] req;
      logic [4:0]  idx;
      logic [14:0] freq;
      logic [1:0]  mult;
      logic [2:0]  div;
      logic [7:0]  r0;
      logic [7:0]  r1;
      logic [7:0]  r2;
   } vec_t;

   // request -> expected match, table fields and seeded registers 0..2
   localparam int NVEC = 7;
   localparam vec_t VEC [NVEC] = '{
      '{15'd6680,  5'd0,  15'd6680,  2'd1, 3'd2, 8'h00, 8'h02, 8'h01},  // R2 exact
      '{15'd6000,  5'd0,  15'd6680,  2'd1, 3'd2, 8'h00, 8'h02, 8'h01},  // R3 odd entry masked
      '{15'd7915,  5'd2,  15'd7500,  2'd1, 3'd2, 8'h10, 8'h00, 8'h01},  // R2 equal gap tie
      '{15'd7500,  5'd2,  15'd7500,  2'd1, 3'd2, 8'h10, 8'h00, 8'h01},  // R2 duplicate at 8
      '{15'd16600, 5'd10, 15'd13300, 2'd2, 3'd4, 8'h50, 8'h00, 8'h00},  // R4 stop at zero
      '{15'd8400,  5'd4,  15'd8330,  2'd2, 3'd3, 8'h20, 8'h02, 8'h01},  // R2
      '{15'd10100, 5'd6,  15'd10000, 2'd2, 3'd3, 8'h30, 8'h00, 8'h01}   // R2
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [14:0] req_freq = '0;
   logic        wr_en = 1'b0, wr_en2 = 1'b0;
   logic [2:0]  wr_addr = '0, rd_addr = '0;
   logic [7:0]  wr_data = '0;
   logic [7:0]  rd_data, rd_data2;
   logic [4:0]  sel_idx, sel_idx2;
   logic [14:0] bus_freq, bus_freq2;
   logic [1:0]  mem_mult, mem_mult2;
   logic [2:0]  pci_div, pci_div2;
   logic        done, done2;
   int          checks = 0;
   int          errors = 0;

   always #2 clk = ~clk;

   clkfs_resolver i_clkfs_resolver (
      .clk(clk), .rst_n(rst_n), .req_freq(req_freq), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .sel_idx(sel_idx),
      .bus_freq(bus_freq), .mem_mult(mem_mult), .pci_div(pci_div), .done(done)
   );

   clkfs_resolver #(.HW_REG(7)) i_clkfs_resolver_nohw (
      .clk(clk), .rst_n(rst_n), .req_freq(req_freq), .wr_en(wr_en2), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data2), .sel_idx(sel_idx2),
      .bus_freq(bus_freq2), .mem_mult(mem_mult2), .pci_div(pci_div2), .done(done2)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   task automatic start(input logic [14:0] req, input bit poke_early);
      @(negedge clk);
      rst_n = 1'b0;
      req_freq = req;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 done low during search", {31'd0, done}, 32'd0);
      chk("R1 index zero during search", {27'd0, sel_idx}, 32'd0);
      if (poke_early) begin
         wr_en = 1'b1; wr_addr = 3'd0; wr_data = 8'h38;
         @(negedge clk);
         wr_en = 1'b0;
      end
      for (int n = 0; n < 100; n++) begin
         if (done && done2) break;
         @(negedge clk);
      end
   endtask

   task automatic wr(input logic inst2, input logic [2:0] a, input logic [7:0] d);
      wr_addr = a; wr_data = d;
      if (inst2) wr_en2 = 1'b1; else wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; wr_en2 = 1'b0;
      @(negedge clk);
   endtask

   task automatic chk_out(input string tag, input logic [4:0] i, input logic [14:0] f,
                          input logic [1:0] m, input logic [2:0] d);
      chk({tag, " index"}, {27'd0, sel_idx}, {27'd0, i});
      chk({tag, " freq"},  {17'd0, bus_freq}, {17'd0, f});
      chk({tag, " mult"},  {30'd0, mem_mult}, {30'd0, m});
      chk({tag, " div"},   {29'd0, pci_div}, {29'd0, d});
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL R11 watchdog expired actual=0 expected=1");
      finish_run();
   end

   initial begin
      // R1: state while reset is held
      repeat (2) @(negedge clk);
      chk("R1 done in reset", {31'd0, done}, 32'd0);
      chk("R1 freq in reset", {17'd0, bus_freq}, 32'd0);

      // vector walk: R2, R3, R4, R5 and R8 (nohw copy must agree)
      for (int v = 0; v < NVEC; v++) begin
         start(VEC[v].req, 1'b0);
         chk("R11 done after search", {31'd0, done}, 32'd1);
         chk_out("R2 R3 R4 match", VEC[v].idx, VEC[v].freq, VEC[v].mult, VEC[v].div);
         chk("R8 nohw index", {27'd0, sel_idx2}, {27'd0, VEC[v].idx});
         rd_addr = 3'd0; #1;
         chk("R5 seeded reg0", {24'd0, rd_data}, {24'd0, VEC[v].r0});
         rd_addr = 3'd1; #1;
         chk("R5 seeded reg1", {24'd0, rd_data}, {24'd0, VEC[v].r1});
         rd_addr = 3'd2; #1;
         chk("R5 seeded reg2", {24'd0, rd_data}, {24'd0, VEC[v].r2});
      end

      // R10: a write during the search is dropped
      start(15'd6680, 1'b1);
      rd_addr = 3'd0; #1;
      chk("R10 early write dropped reg0", {24'd0, rd_data}, 32'h00);
      chk("R10 early write index", {27'd0, sel_idx}, 32'd0);

      // R7 / R9: programmable mode, hw-select bit 3 of reg0 set
      wr(1'b0, 3'd0, 8'h38);
      chk_out("R7 R9 prog idx6", 5'd6, 15'd10000, 2'd2, 3'd3);
      wr(1'b0, 3'd0, 8'h48);
      chk_out("R7 R9 prog idx8", 5'd8, 15'd7500, 2'd3, 3'd4);
      wr(1'b0, 3'd0, 8'h68);
      chk_out("R9 zero entry idx12", 5'd12, 15'd0, 2'd0, 3'd0);
      wr(1'b0, 3'd0, 8'h78);
      chk_out("R9 past terminator idx14", 5'd14, 15'd16600, 2'd2, 3'd6);

      // R6: hw-select bit clear returns to the power-up match
      wr(1'b0, 3'd0, 8'h70);
      chk_out("R6 strap ignores reg bits", 5'd0, 15'd6680, 2'd1, 3'd2);
      chk("R11 done held", {31'd0, done}, 32'd1);

      // R8: no hw-select bit, bit 3 clear still programs the index
      wr(1'b1, 3'd0, 8'h20);
      chk("R8 nohw prog index", {27'd0, sel_idx2}, 32'd4);
      chk("R8 nohw prog freq", {17'd0, bus_freq2}, 32'd8330);

      finish_run();
   end
endmodule